// File: doc/BRIEF.md
# External Interrupt Pin Capture Unit

This block watches a small group of external interrupt pins and turns activity on them into sticky per-pin flags that an interrupt controller can consume. Every pin first passes through a multi-flop synchroniser. Per pin, software chooses whether the flag is set by an edge or by a level, and whether the active sense is low/falling (the default) or high/rising.

A flag stays set until software writes a 1 to its bit in the flag register. Writing a 0 leaves the flag alone. In level mode a flag cannot be cleared while its pin is still at the active level. When a new edge and a clear land in the same cycle, the edge wins. Each flag is gated by an enable bit to form a registered request line per pin. A registered OR of all the gated flags is also provided.

Software reaches the mode, polarity, enable and flag registers through a simple single-cycle register bus. Reads return data one cycle after the read strobe.

Top module: `eint_capture`

## Requirements
- R1: Register at address 0 is the sense-mode register. For each pin i, bit i = 1 selects edge sensing and bit i = 0 selects level sensing. Pin 3 is therefore controlled by mask 0x08.
- R2: With edge sensing and polarity bit 0, a falling edge on the synchronised pin sets that pin's flag, and a rising edge does not.
- R3: Register at address 1 is the polarity register. Bit i = 1 makes pin i respond to a rising edge (edge mode) or to a high level (level mode) instead of falling/low.
- R4: A flag is sticky. It stays set after the pin returns to idle, so one edge yields exactly one flag until software clears it.
- R5: Register at address 3 reads back the flags. A write to it clears every flag whose data bit is 1 and leaves the flags whose data bit is 0 unchanged.
- R6: With level sensing, the flag is set whenever the pin is at its active level. A clear written while the pin is still active has no effect. After the pin goes idle, the flag stays set until a clear is written.
- R7: When an edge is detected in the same cycle as a write-1 clear of that flag, the flag remains set.
- R8: Register at address 2 is the enable register. Output irq_req[i] equals flag i AND enable bit i, registered one cycle after the flag. Output irq_any is the registered OR of those gated flags.
- R9: A pin change made before clock edge k shows on irq_req at edge k+3: two synchroniser edges, one flag edge and one request edge.
- R10: Synchronous reset clears the mode, polarity, enable and flag registers, irq_req, irq_any and bus_rdata.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_in | input | NUM_PINS | Asynchronous external interrupt pins |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 2 | Register select: 0 mode, 1 polarity, 2 enable, 3 flags |
| bus_wdata | input | NUM_PINS | Write data |
| bus_rdata | output | NUM_PINS | Read data, valid the cycle after bus_rd |
| irq_req | output | NUM_PINS | Per-pin request lines: flag AND enable |
| irq_any | output | 1 | OR of all enabled flags |

## Verification
The collision that matters is between an edge being detected and software clearing the same flag. The bench provokes it by changing a pin and timing a flag-register write so that the clear strobe sits in exactly the cycle where the synchronised edge reaches the flag logic. It then reads the flag back and expects it to be 1. A control case, in which the clear lands one cycle later, must leave the flag at 0. A related case covers level mode, where the clear coincides with the pin still being active; there too the flag is expected to survive.

// File: rtl/eint_pkg.sv
package eint_pkg;
  localparam int REG_ADDR_W = 2;

  typedef enum logic [REG_ADDR_W-1:0] {
    SEL_MODE = 2'd0,
    SEL_POL  = 2'd1,
    SEL_EN   = 2'd2,
    SEL_FLAG = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/eint_sync.sv
// Multi-stage synchroniser for a vector of asynchronous pins.
// Stages reset to 1 so that idle-high pins give no spurious edge.
module eint_sync #(
  parameter int WIDTH  = 4,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);
  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk) begin
    if (rst) stage_q[0] <= '1;
    else     stage_q[0] <= async_in;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stage_q[s] <= '1;
      else     stage_q[s] <= stage_q[s-1];
    end
  end

  assign sync_out = stage_q[STAGES-1];
endmodule

// File: rtl/eint_channel.sv
// One capture channel: edge/level detection and a sticky flag.
module eint_channel (
  input  logic clk,
  input  logic rst,
  input  logic sync_lvl,   // synchronised pin level
  input  logic edge_mode,  // 1 = edge, 0 = level
  input  logic rise_pol,   // 1 = rising/high, 0 = falling/low
  input  logic clr,        // write-1 clear strobe
  output logic flag,
  output logic hit,        // set condition this cycle
  output logic active      // pin at its active level
);
  logic prev_q;
  logic rise_seen;
  logic fall_seen;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b1;
    else     prev_q <= sync_lvl;
  end

  assign rise_seen = sync_lvl & ~prev_q;
  assign fall_seen = ~sync_lvl & prev_q;
  assign active    = rise_pol ? sync_lvl : ~sync_lvl;

  always_comb begin
    if (edge_mode) hit = rise_pol ? rise_seen : fall_seen;
    else           hit = active;
  end

  // set has priority over clear (covers edge/clear collision and
  // level mode with the pin still asserted)
  always_ff @(posedge clk) begin
    if (rst)      flag <= 1'b0;
    else if (hit) flag <= 1'b1;
    else if (clr) flag <= 1'b0;
  end
endmodule

// File: rtl/eint_regs.sv
// Configuration registers, write-1-clear decode and registered read mux.
module eint_regs
  import eint_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  bus_wr,
  input  logic                  bus_rd,
  input  logic [REG_ADDR_W-1:0] bus_addr,
  input  logic [WIDTH-1:0]      bus_wdata,
  input  logic [WIDTH-1:0]      flags,
  output logic [WIDTH-1:0]      bus_rdata,
  output logic [WIDTH-1:0]      mode_q,
  output logic [WIDTH-1:0]      pol_q,
  output logic [WIDTH-1:0]      en_q,
  output logic [WIDTH-1:0]      clr_v
);
  reg_sel_e sel;
  logic [WIDTH-1:0] rd_mux;

  assign sel = reg_sel_e'(bus_addr);

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= '0;
      pol_q  <= '0;
      en_q   <= '0;
    end else if (bus_wr) begin
      case (sel)
        SEL_MODE: mode_q <= bus_wdata;
        SEL_POL:  pol_q  <= bus_wdata;
        SEL_EN:   en_q   <= bus_wdata;
        default:  ;
      endcase
    end
  end

  assign clr_v = (bus_wr && sel == SEL_FLAG) ? bus_wdata : '0;

  always_comb begin
    case (sel)
      SEL_MODE: rd_mux = mode_q;
      SEL_POL:  rd_mux = pol_q;
      SEL_EN:   rd_mux = en_q;
      default:  rd_mux = flags;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_mux;
  end
endmodule

// File: rtl/eint_capture.sv
// Top: external interrupt pin capture unit.
module eint_capture #(
  parameter int NUM_PINS    = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_PINS-1:0] pin_in,
  input  logic                bus_wr,
  input  logic                bus_rd,
  input  logic [1:0]          bus_addr,
  input  logic [NUM_PINS-1:0] bus_wdata,
  output logic [NUM_PINS-1:0] bus_rdata,
  output logic [NUM_PINS-1:0] irq_req,
  output logic                irq_any
);
  logic [NUM_PINS-1:0] sync_v;
  logic [NUM_PINS-1:0] mode_q;
  logic [NUM_PINS-1:0] pol_q;
  logic [NUM_PINS-1:0] en_q;
  logic [NUM_PINS-1:0] clr_v;
  logic [NUM_PINS-1:0] flag_q;
  logic [NUM_PINS-1:0] hit_v;
  logic [NUM_PINS-1:0] act_v;
  logic [NUM_PINS-1:0] gated;

  eint_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .async_in(pin_in), .sync_out(sync_v)
  );

  eint_regs #(.WIDTH(NUM_PINS)) u_regs (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .flags(flag_q),
    .bus_rdata(bus_rdata), .mode_q(mode_q), .pol_q(pol_q),
    .en_q(en_q), .clr_v(clr_v)
  );

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_chan
    eint_channel u_chan (
      .clk(clk), .rst(rst), .sync_lvl(sync_v[i]), .edge_mode(mode_q[i]),
      .rise_pol(pol_q[i]), .clr(clr_v[i]), .flag(flag_q[i]),
      .hit(hit_v[i]), .active(act_v[i])
    );
  end

  assign gated = flag_q & en_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_req <= '0;
      irq_any <= 1'b0;
    end else begin
      irq_req <= gated;
      irq_any <= |gated;
    end
  end
endmodule

// File: rtl/eint_capture_chk.sv
module eint_capture_chk #(
  parameter int NUM_PINS = 4
) (
  input logic                clk,
  input logic                rst,
  input logic [NUM_PINS-1:0] mode_q,
  input logic [NUM_PINS-1:0] en_q,
  input logic [NUM_PINS-1:0] flag_q,
  input logic [NUM_PINS-1:0] clr_v,
  input logic [NUM_PINS-1:0] hit_v,
  input logic [NUM_PINS-1:0] act_v,
  input logic [NUM_PINS-1:0] irq_req,
  input logic                irq_any
);
  // R10
  reset_clear_chk: assert property (@(posedge clk)
    $past(rst) |-> (flag_q == '0 && irq_req == '0 && !irq_any));

  // R8
  req_gate_chk: assert property (@(posedge clk) disable iff (rst)
    irq_req == $past(flag_q & en_q));

  // R8
  any_gate_chk: assert property (@(posedge clk) disable iff (rst)
    irq_any == $past(|(flag_q & en_q)));

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    // R7
    set_wins_chk: assert property (@(posedge clk) disable iff (rst)
      hit_v[i] |=> flag_q[i]);

    // R6
    level_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (!mode_q[i] && act_v[i] && clr_v[i]) |=> flag_q[i]);

    // R4
    sticky_chk: assert property (@(posedge clk) disable iff (rst)
      (flag_q[i] && !clr_v[i]) |=> flag_q[i]);

    // R5
    fall_by_clear_chk: assert property (@(posedge clk) disable iff (rst)
      $fell(flag_q[i]) |-> $past(clr_v[i]));
  end
endmodule

bind eint_capture eint_capture_chk #(.NUM_PINS(NUM_PINS)) u_chk (
  .clk(clk), .rst(rst), .mode_q(mode_q), .en_q(en_q), .flag_q(flag_q),
  .clr_v(clr_v), .hit_v(hit_v), .act_v(act_v), .irq_req(irq_req),
  .irq_any(irq_any)
);

// File: tb/sim_eint_capture.sv
`timescale 1ns/1ps
module sim_eint_capture;
  localparam int N = 4;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [N-1:0] pin_in = '1;
  logic         bus_wr = 1'b0;
  logic         bus_rd = 1'b0;
  logic [1:0]   bus_addr = '0;
  logic [N-1:0] bus_wdata = '0;
  logic [N-1:0] bus_rdata;
  logic [N-1:0] irq_req;
  logic         irq_any;

  int total = 0;
  int bad = 0;
  logic [N-1:0] rd;

  always #5 clk = ~clk;

  eint_capture #(.NUM_PINS(N)) u0 (
    .clk(clk), .rst(rst), .pin_in(pin_in), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_req(irq_req), .irq_any(irq_any)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [N-1:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic rdreg(input logic [1:0] a, output logic [N-1:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic act_lvl(input logic p, input logic pol);
    return pol ? p : ~p;
  endfunction

  // expected flag after a settled pin step
  function automatic logic next_flag(input logic f, input logic md, input logic pol,
                                     input logic p_old, input logic p_new);
    if (md) return f | (act_lvl(p_new, pol) & ~act_lvl(p_old, pol));
    return f | act_lvl(p_new, pol);
  endfunction

  initial begin
    #1500000;
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [N-1:0] m, pl, en, ef, pins_old, pins_new, cm;
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R10: reset state
    check("R10 req", irq_req, 0);
    check("R10 any", irq_any, 0);
    check("R10 rdata", bus_rdata, 0);
    rdreg(2'd0, rd); check("R10 mode", rd, 0);
    rdreg(2'd1, rd); check("R10 pol", rd, 0);
    rdreg(2'd2, rd); check("R10 en", rd, 0);
    rdreg(2'd3, rd); check("R10 flags", rd, 0);

    // R9: latency, pin 0 edge mode falling
    wr(2'd0, 4'b0001); wr(2'd2, 4'b1111); wr(2'd3, 4'b1111);
    idle(3);
    pin_in[0] = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk); check("R9 not yet", irq_req[0], 0);
    @(posedge clk); @(negedge clk); check("R9 at k+3", irq_req[0], 1);
    check("R8 any", irq_any, 1);

    // R2/R4: rising edge back does not clear or re-set; sticky
    pin_in[0] = 1'b1; idle(6);
    rdreg(2'd3, rd); check("R4 sticky", rd, 4'b0001);
    wr(2'd3, 4'b1110); idle(2);
    rdreg(2'd3, rd); check("R5 write0 keeps", rd, 4'b0001);
    wr(2'd3, 4'b0001); idle(2);
    rdreg(2'd3, rd); check("R5 write1 clears", rd, 0);
    idle(6);
    rdreg(2'd3, rd); check("R2 rising ignored", rd, 0);

    // R3: pin 1 rising edge
    wr(2'd0, 4'b0011); wr(2'd1, 4'b0010);
    pin_in[1] = 1'b0; idle(6); wr(2'd3, 4'b1111); idle(2);
    rdreg(2'd3, rd); check("R3 falling ignored", rd, 0);
    pin_in[1] = 1'b1; idle(6);
    rdreg(2'd3, rd); check("R3 rising sets", rd, 4'b0010);
    wr(2'd3, 4'b0010);

    // R6: pin 2 level mode low active
    pin_in[2] = 1'b0; idle(6);
    rdreg(2'd3, rd); check("R6 level sets", rd[2], 1);
    wr(2'd3, 4'b0100); idle(2);
    rdreg(2'd3, rd); check("R6 clear ignored while active", rd[2], 1);
    pin_in[2] = 1'b1; idle(6);
    rdreg(2'd3, rd); check("R6 held after idle", rd[2], 1);
    wr(2'd3, 4'b0100); idle(2);
    rdreg(2'd3, rd); check("R6 clear after idle", rd[2], 0);

    // R1: pin 3 edge via 0x08: clear works while pin still low
    wr(2'd0, 4'b1011);
    pin_in[3] = 1'b0; idle(6);
    rdreg(2'd3, rd); check("R1 edge sets", rd[3], 1);
    wr(2'd3, 4'b1000); idle(2);
    rdreg(2'd3, rd); check("R1 edge clear while low", rd[3], 0);
    pin_in[3] = 1'b1; idle(6);

    // R8: enable mask
    wr(2'd2, 4'b0000);
    pin_in[0] = 1'b0; idle(6);
    check("R8 masked req", irq_req, 0);
    check("R8 masked any", irq_any, 0);
    wr(2'd2, 4'b0001); idle(2);
    check("R8 enabled req", irq_req, 4'b0001);
    pin_in[0] = 1'b1; idle(6);
    wr(2'd3, 4'b1111); idle(2);

    // R7: edge and clear in the same cycle
    pin_in[0] = 1'b0;                  // before edge k
    @(posedge clk); @(posedge clk);    // k, k+1
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = 2'd3; bus_wdata = 4'b0001;
    @(posedge clk);                    // k+2: edge and clear collide
    @(negedge clk); bus_wr = 1'b0; bus_wdata = '0;
    rdreg(2'd3, rd); check("R7 edge beats clear", rd[0], 1);
    pin_in[0] = 1'b1; idle(6); wr(2'd3, 4'b1111); idle(2);
    // control: clear one cycle after the flag is set
    pin_in[0] = 1'b0;
    @(posedge clk); @(posedge clk); @(posedge clk);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = 2'd3; bus_wdata = 4'b0001;
    @(negedge clk); bus_wr = 1'b0; bus_wdata = '0;
    rdreg(2'd3, rd); check("R7 later clear wins", rd[0], 0);
    pin_in[0] = 1'b1; idle(6);

    // random configurations and settled pin patterns
    for (int t = 0; t < 40; t++) begin
      m = N'($urandom); pl = N'($urandom); en = N'($urandom);
      wr(2'd1, pl);
      pin_in = ~pl; idle(6);
      wr(2'd0, m); wr(2'd2, en);
      wr(2'd3, '1); idle(3);
      ef = '0;
      pins_old = ~pl;
      for (int s = 0; s < 1 + int'($urandom % 3); s++) begin
        pins_new = N'($urandom);
        pin_in = pins_new; idle(6);
        for (int i = 0; i < N; i++)
          ef[i] = next_flag(ef[i], m[i], pl[i], pins_old[i], pins_new[i]);
        pins_old = pins_new;
      end
      rdreg(2'd3, rd); check("R2 R3 R6 random flags", rd, ef);
      check("R8 random req", irq_req, ef & en);
      check("R8 random any", irq_any, |(ef & en));
      cm = N'($urandom);
      wr(2'd3, cm); idle(3);
      for (int i = 0; i < N; i++)
        if (cm[i] && !(!m[i] && act_lvl(pins_old[i], pl[i]))) ef[i] = 1'b0;
      rdreg(2'd3, rd); check("R5 R6 random clear", rd, ef);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule